// File: doc/BRIEF.md
# Banked Dual-Lane Data Register File

This block is the general-purpose data register file for a datapath with two SIMD lanes, X and Y. Each lane keeps two banks of sixteen 32-bit registers, a primary and a shadow bank. A registered bank-select bit decides which bank every port sees. An interrupt handler can therefore swap its whole working set in one step and swap back on return, without saving anything to memory.

Lane X always takes part in every access. Lane Y joins only while a registered SIMD enable is set. Then one 4-bit register index on a port reaches the same register in both lanes, and each access moves one word per lane. The block has six read ports and four write ports, shared by the computation units and the memory-transfer paths.

Reads are combinational from the stored state. Writes commit at the rising clock edge. The ports are plain register-file ports, with no valid/ready handshake: a read is always served, and a write is accepted whenever its enable is high, so there is no back-pressure.

Top module: `dlrf_top`

## Requirements
- R1: During and right after reset, every register of both banks in both lanes reads 0, the primary bank (select value 0) is active and SIMD is off.
- R2: A write is visible on the read ports from the cycle after its clock edge. A read of the same register in the cycle of the write returns the previous value.
- R3: With the registered select at 1, all ports address the shadow bank; with it at 0, the primary bank. Contents of the bank not selected are never changed, so switching back restores the earlier values.
- R4: A change on the bank-select or SIMD-enable input takes effect for accesses in the cycle after the clock edge that samples it; accesses in the same cycle still use the old mode.
- R5: When several write ports with enable high name the same register in one cycle, the value from the highest-numbered port is stored.
- R6: While SIMD is off, writes change lane X only; every lane Y register keeps its value.
- R7: While SIMD is off, all lane Y read outputs are 0. While it is on, they return lane Y registers at the addressed index.
- R8: While SIMD is on, a write port stores its X data into lane X and its Y data into lane Y, at the same index and bank.
- R9: The six read ports are independent: each returns the register at its own address in the same cycle, including when several ports share an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 1 | Bank select: 0 primary, 1 shadow (registered) |
| simd_en_i | input | 1 | Lane Y enable (registered) |
| rd_addr_i | input | 6x4 | Register index for each read port |
| rd_data_x_o | output | 6x32 | Lane X read data for each port |
| rd_data_y_o | output | 6x32 | Lane Y read data for each port, 0 when SIMD is off |
| wr_en_i | input | 4 | Write enable for each write port |
| wr_addr_i | input | 4x4 | Register index for each write port |
| wr_data_x_i | input | 4x32 | Lane X write data for each port |
| wr_data_y_i | input | 4x32 | Lane Y write data for each port |

## Verification
Read data is combinational, so a read reflects the current state in the same cycle. Written data and a new mode appear exactly one rising edge after they are applied. The bench drives every stimulus just after a falling edge and samples 1 ns later. It checks the old value in that same half-cycle and the new value just after the next falling edge. No check depends on how processes are ordered at the active edge.

// File: rtl/dlrf_pkg.sv
package dlrf_pkg;
  localparam int DLRF_DW    = 32;
  localparam int DLRF_NREG  = 16;
  localparam int DLRF_NRD   = 6;
  localparam int DLRF_NWR   = 4;
  localparam int DLRF_NLANE = 2;
  localparam int DLRF_NBANK = 2;

  typedef struct packed {
    logic shadow;
    logic simd;
  } dlrf_mode_t;
endpackage

// File: rtl/dlrf_mode.sv
module dlrf_mode
  import dlrf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_sel_i,
  input  logic       simd_en_i,
  output dlrf_mode_t mode_o
);
  dlrf_mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      mode_q.shadow <= bank_sel_i;
      mode_q.simd   <= simd_en_i;
    end
  end

  assign mode_o = mode_q;

  always_comb begin
    if (!rst_n) begin
      AST_RESET_MODE: assert (mode_q == '0); // R1
    end
  end

  AST_BANK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_q.shadow == $past(bank_sel_i)); // R4

  AST_SIMD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_q.simd == $past(simd_en_i)); // R4
endmodule

// File: rtl/dlrf_wr_resolve.sv
module dlrf_wr_resolve #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int NWR  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NWR-1:0]          wr_en_i,
  input  logic [NWR-1:0][AW-1:0]  wr_addr_i,
  input  logic [NWR-1:0][DW-1:0]  wr_data_i,
  output logic [NREG-1:0]         hit_o,
  output logic [NREG-1:0][DW-1:0] val_o
);
  // Ports are scanned in ascending order so a later (higher) port overrides.
  always_comb begin
    hit_o = '0;
    val_o = '0;
    for (int r = 0; r < NREG; r++) begin
      for (int p = 0; p < NWR; p++) begin
        if (wr_en_i[p] && (int'(wr_addr_i[p]) == r)) begin
          hit_o[r] = 1'b1;
          val_o[r] = wr_data_i[p];
        end
      end
    end
  end
endmodule

// File: rtl/dlrf_lane.sv
module dlrf_lane #(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int NRD   = 6,
  parameter int NWR   = 4,
  parameter int NBANK = 2,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lane_en_i,
  input  logic [BW-1:0]          bank_i,
  input  logic [NWR-1:0]         wr_en_i,
  input  logic [NWR-1:0][AW-1:0] wr_addr_i,
  input  logic [NWR-1:0][DW-1:0] wr_data_i,
  input  logic [NRD-1:0][AW-1:0] rd_addr_i,
  output logic [NRD-1:0][DW-1:0] rd_data_o
);
  logic [NREG-1:0]                   hit;
  logic [NREG-1:0][DW-1:0]           val;
  logic [NBANK-1:0][NREG-1:0][DW-1:0] mem_q;

  dlrf_wr_resolve #(.DW(DW), .NREG(NREG), .NWR(NWR)) u_resolve (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .hit_o     (hit),
    .val_o     (val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (lane_en_i) begin
      for (int r = 0; r < NREG; r++) begin
        if (hit[r]) begin
          mem_q[bank_i][r] <= val[r];
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[bank_i][rd_addr_i[p]];
  end

  AST_IDLE_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en_i |=> $stable(mem_q)); // R6

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
    AST_UNSELECTED_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bank_i) != b) |=> $stable(mem_q[b])); // R3
  end

  AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en_i && wr_en_i[NWR-1])
    |=> mem_q[$past(bank_i)][$past(wr_addr_i[NWR-1])] == $past(wr_data_i[NWR-1])); // R5
endmodule

// File: rtl/dlrf_top.sv
module dlrf_top
  import dlrf_pkg::*;
#(
  parameter int DW   = DLRF_DW,
  parameter int NREG = DLRF_NREG,
  parameter int NRD  = DLRF_NRD,
  parameter int NWR  = DLRF_NWR,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bank_sel_i,
  input  logic                   simd_en_i,
  input  logic [NRD-1:0][AW-1:0] rd_addr_i,
  output logic [NRD-1:0][DW-1:0] rd_data_x_o,
  output logic [NRD-1:0][DW-1:0] rd_data_y_o,
  input  logic [NWR-1:0]         wr_en_i,
  input  logic [NWR-1:0][AW-1:0] wr_addr_i,
  input  logic [NWR-1:0][DW-1:0] wr_data_x_i,
  input  logic [NWR-1:0][DW-1:0] wr_data_y_i
);
  localparam int NLANE = DLRF_NLANE;

  dlrf_mode_t                          mode;
  logic [NLANE-1:0]                    lane_en;
  logic [NLANE-1:0][NWR-1:0][DW-1:0]   wdat;
  logic [NLANE-1:0][NRD-1:0][DW-1:0]   rdat;

  dlrf_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel_i (bank_sel_i),
    .simd_en_i  (simd_en_i),
    .mode_o     (mode)
  );

  assign wdat[0] = wr_data_x_i;
  assign wdat[1] = wr_data_y_i;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    if (l == 0) begin : g_always
      assign lane_en[l] = 1'b1;
    end else begin : g_simd
      assign lane_en[l] = mode.simd;
    end

    dlrf_lane #(.DW(DW), .NREG(NREG), .NRD(NRD), .NWR(NWR), .NBANK(DLRF_NBANK)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_en_i (lane_en[l]),
      .bank_i    (mode.shadow),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wdat[l]),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rdat[l])
    );
  end

  assign rd_data_x_o = rdat[0];
  assign rd_data_y_o = mode.simd ? rdat[1] : '0;

  AST_SIMD_OFF_Y_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !simd_en_i |=> rd_data_y_o == '0); // R7
endmodule

// File: tb/dlrf_top_tb_top.sv
`timescale 1ns/1ps
module dlrf_top_tb_top;
  localparam int DW = 32, NREG = 16, NRD = 6, NWR = 4, AW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                   rst_n;
  logic                   bank_sel, simd_en;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_x, rd_y;
  logic [NWR-1:0]         wr_en;
  logic [NWR-1:0][AW-1:0] wr_addr;
  logic [NWR-1:0][DW-1:0] wr_x, wr_y;

  dlrf_top dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel), .simd_en_i(simd_en),
    .rd_addr_i(rd_addr), .rd_data_x_o(rd_x), .rd_data_y_o(rd_y),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_x_i(wr_x), .wr_data_y_i(wr_y)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic t_reset();
    for (int base = 0; base < NREG; base += NRD) begin
      for (int p = 0; p < NRD; p++) rd_addr[p] = AW'((base + p) % NREG);
      #1;
      for (int p = 0; p < NRD; p++) begin
        chk("R1 x after reset", rd_x[p], '0);
        chk("R1 y after reset", rd_y[p], '0);
      end
      next_cycle();
    end
  endtask

  task automatic t_write_read();
    wr_en[0] = 1'b1; wr_addr[0] = 4'd5; wr_x[0] = 32'hA5A5_0005;
    rd_addr[0] = 4'd5;
    #1 chk("R2 same-cycle read old", rd_x[0], '0);
    next_cycle();
    #1 chk("R2 next-cycle read new", rd_x[0], 32'hA5A5_0005);
  endtask

  task automatic t_priority();
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = 1'b1; wr_addr[p] = 4'd7; wr_x[p] = 32'h7000_0000 + p;
    end
    next_cycle();
    rd_addr[1] = 4'd7;
    #1 chk("R5 four ports same reg", rd_x[1], 32'h7000_0003);
    wr_en[1] = 1'b1; wr_addr[1] = 4'd9; wr_x[1] = 32'h9000_0001;
    wr_en[2] = 1'b1; wr_addr[2] = 4'd9; wr_x[2] = 32'h9000_0002;
    next_cycle();
    rd_addr[1] = 4'd9;
    #1 chk("R5 ports 1 and 2 same reg", rd_x[1], 32'h9000_0002);
  endtask

  task automatic t_bank();
    bank_sel = 1'b1;
    rd_addr[0] = 4'd5;
    #1 chk("R4 old bank same cycle", rd_x[0], 32'hA5A5_0005);
    next_cycle();
    #1 chk("R3 shadow reg starts zero", rd_x[0], '0);
    wr_en[3] = 1'b1; wr_addr[3] = 4'd5; wr_x[3] = 32'hB0B0_0005;
    next_cycle();
    #1 chk("R3 shadow write", rd_x[0], 32'hB0B0_0005);
    bank_sel = 1'b0;
    next_cycle();
    #1 chk("R3 primary restored", rd_x[0], 32'hA5A5_0005);
    bank_sel = 1'b1;
    next_cycle();
    #1 chk("R3 shadow kept", rd_x[0], 32'hB0B0_0005);
    bank_sel = 1'b0;
    next_cycle();
  endtask

  task automatic t_simd();
    wr_en[0] = 1'b1; wr_addr[0] = 4'd3; wr_x[0] = 32'hC0C0_0003; wr_y[0] = 32'hD0D0_0003;
    rd_addr[2] = 4'd3;
    next_cycle();
    #1 chk("R7 y quiet while off", rd_y[2], '0);
    chk("R6 x written while off", rd_x[2], 32'hC0C0_0003);
    simd_en = 1'b1;
    #1 chk("R4 simd not yet on", rd_y[2], '0);
    next_cycle();
    #1 chk("R6 y reg untouched", rd_y[2], '0);
    wr_en[1] = 1'b1; wr_addr[1] = 4'd3; wr_x[1] = 32'hE0E0_0003; wr_y[1] = 32'hF0F0_0003;
    next_cycle();
    #1 chk("R8 x lane write", rd_x[2], 32'hE0E0_0003);
    chk("R8 y lane write", rd_y[2], 32'hF0F0_0003);
    chk("R7 y visible while on", rd_y[2], 32'hF0F0_0003);
    simd_en = 1'b0;
    next_cycle();
    #1 chk("R7 y quiet after off", rd_y[2], '0);
    wr_en[0] = 1'b1; wr_addr[0] = 4'd3; wr_x[0] = 32'h1111_0003; wr_y[0] = 32'h2222_0003;
    next_cycle();
    simd_en = 1'b1;
    next_cycle();
    #1 chk("R6 y kept across off write", rd_y[2], 32'hF0F0_0003);
    chk("R6 x took off write", rd_x[2], 32'h1111_0003);
    simd_en = 1'b0;
    next_cycle();
  endtask

  task automatic t_ports();
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = 1'b1; wr_addr[p] = AW'(8 + p); wr_x[p] = 32'h8000_0000 + p;
    end
    next_cycle();
    wr_en[0] = 1'b1; wr_addr[0] = 4'd12; wr_x[0] = 32'h8000_0004;
    wr_en[1] = 1'b1; wr_addr[1] = 4'd13; wr_x[1] = 32'h8000_0005;
    next_cycle();
    for (int p = 0; p < NRD; p++) rd_addr[p] = AW'(8 + p);
    #1;
    for (int p = 0; p < NRD; p++) chk("R9 distinct addresses", rd_x[p], 32'h8000_0000 + p);
    for (int p = 0; p < NRD; p++) rd_addr[p] = AW'(13 - p);
    #1;
    for (int p = 0; p < NRD; p++) chk("R9 reversed addresses", rd_x[p], 32'h8000_0005 - p);
    for (int p = 0; p < NRD; p++) rd_addr[p] = 4'd10;
    #1;
    for (int p = 0; p < NRD; p++) chk("R9 shared address", rd_x[p], 32'h8000_0002);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bank_sel = 1'b0; simd_en = 1'b0;
    rd_addr = '0; wr_en = '0; wr_addr = '0; wr_x = '0; wr_y = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 x during reset", rd_x[0], '0);
    rst_n = 1'b1;
    next_cycle();
    t_reset();
    t_write_read();
    t_priority();
    t_bank();
    t_simd();
    t_ports();
    finish_run();
  end
endmodule